// File: doc/BRIEF.md
# Single-Precision Float to Integer Converter

This unit turns one single-precision floating-point operand into a 64-bit integer. A 2-bit select picks one of four destination formats (signed or unsigned, 32 or 64 bits), a 2-bit rounding control picks the rounding direction, and a 3-bit mode select picks the out-of-range policy. There are three policies. Native saturation sends NaN to the format minimum. Saturating conversion sends NaN to zero. Modular conversion keeps only the low bits of the exact two's-complement integer.

Each conversion is presented with a valid strobe. After one register stage the unit returns the integer, a write enable for the destination, and per-operation status: invalid conversion, signalling NaN, inexact, rounded-away-from-zero (magnitude grew), overflow and illegal mode. The invalid-exception enable turns an invalid operation into a suppressed write. Accumulating the status bits and writing a register file are left to the surrounding pipeline.

Top module: `fcvt_to_int`

## Requirements
- R1: Target select encoding: 0 signed 32-bit, 1 unsigned 32-bit, 2 signed 64-bit, 3 unsigned 64-bit. A 32-bit result is sign-extended (signed) or zero-extended (unsigned) to 64 bits on `res_data`.
- R2: Rounding select encoding: 00 nearest-even, 01 toward zero, 10 toward +infinity, 11 toward -infinity. When mode bit 2 is set, rounding is toward zero whatever the rounding select says.
- R3: Modes 0 and 1: NaN gives the target minimum. A rounded value above the target range gives the target maximum. One below it gives the target minimum. Infinities follow the same rule by sign.
- R4: Modes 2 and 3: NaN gives 0. Out-of-range values and infinities saturate as in R3.
- R5: Modes 4 and 5: infinities and NaN give 0. Any other value is converted exactly, and the low 32 or 64 bits of its two's-complement form are kept, then extended as in R1.
- R6: Modes 6 and 7 raise `flg_illegal` with `res_we` low, `res_data` zero and every other flag low.
- R7: `flg_invalid` and `flg_overflow` are set together when the source is NaN or infinite, or when the rounded value lies outside the target range. In that case `flg_inexact` and `flg_rounded_up` are 0.
- R8: For a conversion that is not invalid, `flg_inexact` is set when the source had a nonzero fraction. `flg_rounded_up` is set when rounding increased the magnitude.
- R9: With `inv_en` high, an invalid or signalling-NaN operation drives `res_we` low and `res_data` to zero. With `inv_en` low it writes the value from R3 to R5.
- R10: A signalling NaN (exponent all ones, fraction nonzero, fraction bit 22 clear) sets `flg_snan` together with `flg_invalid`. A quiet NaN leaves `flg_snan` low.
- R11: Zero converts exactly to 0. A subnormal converts to 0 with inexact set, except that toward +infinity a positive subnormal gives +1, and toward -infinity a negative one gives -1, both with `flg_rounded_up`.
- R12: Outputs appear one clock after the operands. In reset, and in the cycle after an operation without `op_valid`, every output is zero and `res_data` is zero whenever `res_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_src | input | 32 | Single-precision source operand |
| op_tgt | input | 2 | Destination format select |
| op_mode | input | 3 | Conversion mode (policy and forced truncation) |
| op_rnd | input | 2 | Rounding direction select |
| inv_en | input | 1 | Invalid-exception enable |
| res_we | output | 1 | Destination write enable |
| res_data | output | 64 | Integer result |
| flg_invalid | output | 1 | Invalid conversion |
| flg_snan | output | 1 | Signalling NaN source |
| flg_inexact | output | 1 | Result differs from source |
| flg_rounded_up | output | 1 | Rounding increased the magnitude |
| flg_overflow | output | 1 | Overflow status |
| flg_illegal | output | 1 | Reserved mode requested |

## Verification
Directed operands sit on the halfway points ±1.5 and ±2.5, so each rounding direction and forced truncation gives a different integer. Powers of two at 2^31, 2^32, 2^63 and 2^64 land exactly on each format's range edge, which separates the saturate-high, saturate-low and wrap policies from in-range conversion. NaN of both kinds, both infinities, signed zero and the smallest subnormals tell the three NaN policies and the directed-rounding subnormal cases apart. A long run of operands with biased exponents around the integer range, under random format, mode, rounding and enable, is compared against a behavioural model each cycle.

// File: rtl/fcvt_pkg.sv
`timescale 1ns/1ps
package fcvt_pkg;

   typedef enum logic [1:0] {
      TGT_S32 = 2'd0,
      TGT_U32 = 2'd1,
      TGT_S64 = 2'd2,
      TGT_U64 = 2'd3
   } tgt_e;

   typedef enum logic [1:0] {
      RM_NEAR  = 2'd0,
      RM_TRUNC = 2'd1,
      RM_CEIL  = 2'd2,
      RM_FLOOR = 2'd3
   } rm_e;

   typedef enum logic [1:0] {
      POL_NATIVE = 2'd0,
      POL_SAT    = 2'd1,
      POL_WRAP   = 2'd2,
      POL_BAD    = 2'd3
   } pol_e;

   typedef struct packed {
      logic sign;
      logic nan;
      logic snan;
      logic inf;
   } fcls_t;

   // mode pairs share one policy; bits [2:1] select it
   function automatic pol_e mode_policy(input logic [2:0] mode);
      pol_e p;
      case (mode[2:1])
         2'd0:    p = POL_NATIVE;
         2'd1:    p = POL_SAT;
         2'd2:    p = POL_WRAP;
         default: p = POL_BAD;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/fcvt_unpack.sv
`timescale 1ns/1ps
module fcvt_unpack
   import fcvt_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int SIG_W = FRAC_W + 1,
   localparam int SH_W  = EXP_W + 1
) (
   input  logic [EXP_W+FRAC_W:0] src,
   output fcls_t                 cls,
   output logic [SIG_W-1:0]      sig,
   output logic                  lsh_en,
   output logic [SH_W-1:0]       lsh,
   output logic [SH_W-1:0]       rsh
);
   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   // biased exponent at which the significand lsb has weight one
   localparam int PT   = BIAS + FRAC_W;

   if (EXP_W < 3)  begin : g_bad_exp  $error("fcvt_unpack: EXP_W too small");  end
   if (FRAC_W < 2) begin : g_bad_frac $error("fcvt_unpack: FRAC_W too small"); end

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac;
   logic              exp_ones, exp_zero;
   logic [SH_W-1:0]   exp_eff;

   assign exp_f    = src[EXP_W+FRAC_W-1:FRAC_W];
   assign frac     = src[FRAC_W-1:0];
   assign exp_ones = &exp_f;
   assign exp_zero = ~|exp_f;

   always_comb begin
      cls.sign = src[EXP_W+FRAC_W];
      cls.nan  = exp_ones & (|frac);
      cls.snan = exp_ones & (|frac) & ~frac[FRAC_W-1];
      cls.inf  = exp_ones & ~(|frac);
   end

   // subnormals use the minimum normal exponent with no hidden bit
   assign sig     = {~exp_zero, frac};
   assign exp_eff = exp_zero ? SH_W'(1) : {1'b0, exp_f};
   assign lsh_en  = (exp_eff >= SH_W'(PT));
   assign lsh     = lsh_en ? (exp_eff - SH_W'(PT)) : '0;
   assign rsh     = lsh_en ? '0 : (SH_W'(PT) - exp_eff);

endmodule

// File: rtl/fcvt_round.sv
`timescale 1ns/1ps
module fcvt_round
   import fcvt_pkg::*;
#(
   parameter int SIG_W = 24,
   parameter int MAG_W = 128,
   parameter int SH_W  = 9
) (
   input  logic [SIG_W-1:0] sig,
   input  logic             sign,
   input  logic             lsh_en,
   input  logic [SH_W-1:0]  lsh,
   input  logic [SH_W-1:0]  rsh,
   input  rm_e              rm,
   input  logic             force_trunc,
   output logic [MAG_W-1:0] mag,
   output logic             inexact,
   output logic             up
);
   localparam int FIX_W = 2 * SIG_W;

   if (MAG_W < SIG_W + 1) begin : g_bad_mag $error("fcvt_round: MAG_W below SIG_W+1"); end

   logic [FIX_W-1:0] fix;
   logic [SIG_W-1:0] ipart;
   logic             guard, sticky;
   rm_e              eff_rm;

   // split the significand into integer part, guard and sticky bits
   always_comb begin
      fix    = '0;
      ipart  = '0;
      guard  = 1'b0;
      sticky = 1'b0;
      if (!lsh_en) begin
         if (rsh > SH_W'(SIG_W)) begin
            sticky = |sig;
         end else begin
            fix    = {sig, {SIG_W{1'b0}}} >> rsh;
            ipart  = fix[FIX_W-1:SIG_W];
            guard  = fix[SIG_W-1];
            sticky = |fix[SIG_W-2:0];
         end
      end
   end

   assign eff_rm = force_trunc ? RM_TRUNC : rm;

   always_comb begin
      case (eff_rm)
         RM_NEAR:  up = guard & (sticky | ipart[0]);
         RM_CEIL:  up = ~sign & (guard | sticky);
         RM_FLOOR: up = sign & (guard | sticky);
         default:  up = 1'b0;
      endcase
   end

   assign inexact = guard | sticky;
   assign mag     = lsh_en ? (MAG_W'(sig) << lsh)
                           : (MAG_W'(ipart) + MAG_W'(up));

endmodule

// File: rtl/fcvt_policy.sv
`timescale 1ns/1ps
module fcvt_policy
   import fcvt_pkg::*;
#(
   parameter int MAG_W = 128,
   parameter int RES_W = 64
) (
   input  logic             valid,
   input  fcls_t            cls,
   input  logic [MAG_W-1:0] mag,
   input  logic             inexact_in,
   input  logic             up_in,
   input  tgt_e             tgt,
   input  logic [2:0]       mode,
   input  logic             inv_en,
   output logic             we,
   output logic [RES_W-1:0] data,
   output logic             f_inv,
   output logic             f_snan,
   output logic             f_inex,
   output logic             f_up,
   output logic             f_ovf,
   output logic             f_ill
);
   localparam int NAR_W = RES_W / 2;

   if (RES_W % 2 != 0)     begin : g_bad_res  $error("fcvt_policy: RES_W must be even"); end
   if (NAR_W < 2)          begin : g_bad_nar  $error("fcvt_policy: RES_W too small");   end
   if (MAG_W < RES_W + 1)  begin : g_bad_magw $error("fcvt_policy: MAG_W below RES_W+1"); end

   pol_e             pol;
   logic             wide, uns, legal, finite;
   int               k_top;
   logic [MAG_W-1:0] hi_part, lo_mask;
   logic             over, under, inv;
   logic [RES_W-1:0] min_v, max_v, twos, raw, ext;

   assign pol    = mode_policy(mode);
   assign legal  = (pol != POL_BAD);
   assign wide   = tgt[1];
   assign uns    = tgt[0];
   assign finite = ~cls.nan & ~cls.inf;

   // bit position whose weight first exceeds the positive range
   assign k_top   = (wide ? RES_W : NAR_W) - (uns ? 0 : 1);
   assign hi_part = mag >> k_top;
   assign lo_mask = (MAG_W'(1) << k_top) - MAG_W'(1);

   always_comb begin
      over  = ~cls.sign & (cls.inf | (finite & (|hi_part)));
      if (uns)
         under = cls.sign & (cls.inf | (finite & (|mag)));
      else
         under = cls.sign & (cls.inf | (finite &
                 ((hi_part > MAG_W'(1)) |
                  ((hi_part == MAG_W'(1)) & (|(mag & lo_mask))))));
   end

   assign inv = cls.nan | over | under;

   // range ends of the chosen format, already at full width
   always_comb begin
      if (uns)
         min_v = '0;
      else if (wide)
         min_v = {1'b1, {(RES_W-1){1'b0}}};
      else
         min_v = {{(NAR_W+1){1'b1}}, {(NAR_W-1){1'b0}}};
      if (uns && wide)
         max_v = '1;
      else if (uns)
         max_v = {{NAR_W{1'b0}}, {NAR_W{1'b1}}};
      else if (wide)
         max_v = {1'b0, {(RES_W-1){1'b1}}};
      else
         max_v = {{(NAR_W+1){1'b0}}, {(NAR_W-1){1'b1}}};
   end

   // low bits of the wide two's-complement value
   assign twos = cls.sign ? (~mag[RES_W-1:0] + RES_W'(1)) : mag[RES_W-1:0];

   always_comb begin
      raw = twos;
      case (pol)
         POL_NATIVE, POL_SAT: begin
            if (cls.nan)    raw = (pol == POL_NATIVE) ? min_v : '0;
            else if (over)  raw = max_v;
            else if (under) raw = min_v;
         end
         POL_WRAP: begin
            if (!finite) raw = '0;
         end
         default: raw = '0;
      endcase
   end

   always_comb begin
      if (wide)     ext = raw;
      else if (uns) ext = {{NAR_W{1'b0}}, raw[NAR_W-1:0]};
      else          ext = {{NAR_W{raw[NAR_W-1]}}, raw[NAR_W-1:0]};
   end

   logic act, supp;
   assign act    = valid & legal;
   assign supp   = inv_en & (inv | cls.snan);
   assign we     = act & ~supp;
   assign data   = we ? ext : '0;
   assign f_inv  = act & inv;
   assign f_ovf  = act & inv;
   assign f_snan = act & cls.snan;
   assign f_inex = act & ~inv & inexact_in;
   assign f_up   = act & ~inv & up_in;
   assign f_ill  = valid & ~legal;

endmodule

// File: rtl/fcvt_to_int.sv
`timescale 1ns/1ps
module fcvt_to_int
   import fcvt_pkg::*;
#(
   parameter int EXP_W   = 8,
   parameter int FRAC_W  = 23,
   parameter int RES_W   = 64,
   parameter int LATENCY = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    op_valid,
   input  logic [EXP_W+FRAC_W:0]   op_src,
   input  logic [1:0]              op_tgt,
   input  logic [2:0]              op_mode,
   input  logic [1:0]              op_rnd,
   input  logic                    inv_en,
   output logic                    res_we,
   output logic [RES_W-1:0]        res_data,
   output logic                    flg_invalid,
   output logic                    flg_snan,
   output logic                    flg_inexact,
   output logic                    flg_rounded_up,
   output logic                    flg_overflow,
   output logic                    flg_illegal
);
   localparam int SIG_W = FRAC_W + 1;
   localparam int SH_W  = EXP_W + 1;
   localparam int MAG_W = 1 << (EXP_W - 1);
   localparam int NAR_W = RES_W / 2;

   if (LATENCY != 0 && LATENCY != 1) begin : g_bad_lat
      $error("fcvt_to_int: LATENCY must be 0 or 1");
   end

   typedef struct packed {
      logic             we;
      logic [RES_W-1:0] data;
      logic             inv;
      logic             snan;
      logic             inex;
      logic             up;
      logic             ovf;
      logic             ill;
      tgt_e             tgt;
   } out_t;

   fcls_t            cls;
   logic [SIG_W-1:0] sig;
   logic             lsh_en;
   logic [SH_W-1:0]  lsh, rsh;
   logic [MAG_W-1:0] mag;
   logic             r_inex, r_up;
   out_t             nxt, cur;

   fcvt_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
      .src    (op_src),
      .cls    (cls),
      .sig    (sig),
      .lsh_en (lsh_en),
      .lsh    (lsh),
      .rsh    (rsh)
   );

   fcvt_round #(.SIG_W(SIG_W), .MAG_W(MAG_W), .SH_W(SH_W)) u_round (
      .sig         (sig),
      .sign        (cls.sign),
      .lsh_en      (lsh_en),
      .lsh         (lsh),
      .rsh         (rsh),
      .rm          (rm_e'(op_rnd)),
      .force_trunc (op_mode[2]),
      .mag         (mag),
      .inexact     (r_inex),
      .up          (r_up)
   );

   fcvt_policy #(.MAG_W(MAG_W), .RES_W(RES_W)) u_policy (
      .valid      (op_valid),
      .cls        (cls),
      .mag        (mag),
      .inexact_in (r_inex),
      .up_in      (r_up),
      .tgt        (tgt_e'(op_tgt)),
      .mode       (op_mode),
      .inv_en     (inv_en),
      .we         (nxt.we),
      .data       (nxt.data),
      .f_inv      (nxt.inv),
      .f_snan     (nxt.snan),
      .f_inex     (nxt.inex),
      .f_up       (nxt.up),
      .f_ovf      (nxt.ovf),
      .f_ill      (nxt.ill)
   );

   assign nxt.tgt = tgt_e'(op_tgt);

   if (LATENCY == 0) begin : g_comb
      assign cur = nxt;
   end else begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cur <= '0;
         else        cur <= nxt;
      end

      // R12
      idle_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(op_valid) |-> (!res_we && !flg_illegal && !flg_invalid));
   end

   assign res_we         = cur.we;
   assign res_data       = cur.data;
   assign flg_invalid    = cur.inv;
   assign flg_snan       = cur.snan;
   assign flg_inexact    = cur.inex;
   assign flg_rounded_up = cur.up;
   assign flg_overflow   = cur.ovf;
   assign flg_illegal    = cur.ill;

   // R6
   ill_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flg_illegal |-> (!res_we && !flg_invalid && !flg_inexact));

   // R7
   inv_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flg_invalid |-> (!flg_inexact && !flg_rounded_up));

   // R8
   up_inex_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flg_rounded_up |-> flg_inexact);

   // R10
   snan_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flg_snan |-> flg_invalid);

   // R1
   sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_we && cur.tgt == TGT_S32) |->
         (res_data[RES_W-1:NAR_W] == {NAR_W{res_data[NAR_W-1]}}));

   // R9
   nowr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_we |-> (res_data == '0));

endmodule

// File: tb/fcvt_to_int_tb.sv
`timescale 1ns/1ps
module fcvt_to_int_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        op_valid;
   logic [31:0] op_src;
   logic [1:0]  op_tgt;
   logic [2:0]  op_mode;
   logic [1:0]  op_rnd;
   logic        inv_en;
   logic        res_we;
   logic [63:0] res_data;
   logic        flg_invalid, flg_snan, flg_inexact, flg_rounded_up, flg_overflow, flg_illegal;

   always #2.5 clk = ~clk;

   fcvt_to_int u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_src(op_src),
      .op_tgt(op_tgt), .op_mode(op_mode), .op_rnd(op_rnd), .inv_en(inv_en),
      .res_we(res_we), .res_data(res_data), .flg_invalid(flg_invalid),
      .flg_snan(flg_snan), .flg_inexact(flg_inexact), .flg_rounded_up(flg_rounded_up),
      .flg_overflow(flg_overflow), .flg_illegal(flg_illegal)
   );

   typedef struct packed {
      logic        we;
      logic [63:0] d;
      logic        inv, snan, inex, up, ovf, ill;
   } obs_t;

   obs_t  expq[$];
   string tagq[$];
   int    total = 0;
   int    bad   = 0;
   bit    mon_on = 0;
   bit    done   = 0;

   function automatic obs_t ref_conv(input logic v, input logic [31:0] f, input logic [1:0] t,
                                     input logic [2:0] m, input logic [1:0] r, input logic e);
      obs_t o;
      logic s, nan, snan, inf, up, trunc, inv;
      int ex, sc, n;
      logic [22:0] fr;
      logic [23:0] sig;
      logic signed [135:0] ip, rem, half, rnd, val, lo, hi;
      logic [63:0] raw;
      o = '0;
      if (!v) return o;
      if (m >= 3'd6) begin o.ill = 1'b1; return o; end
      s = f[31]; ex = int'(f[30:23]); fr = f[22:0];
      nan  = (ex == 255) && (fr != 0);
      snan = nan && !fr[22];
      inf  = (ex == 255) && (fr == 0);
      if (ex == 0) begin sig = {1'b0, fr}; sc = -149; end
      else         begin sig = {1'b1, fr}; sc = ex - 150; end
      rem = 0; half = 1;
      ip = 136'(sig);
      if (sc >= 0) ip = ip << sc;
      else if (-sc > 60) begin ip = 0; rem = 136'(sig); half = 136'(1) << 60; end
      else begin
         ip   = 136'(sig) >> (-sc);
         rem  = 136'(sig) - (ip << (-sc));
         half = 136'(1) << (-sc - 1);
      end
      trunc = m[2] || (r == 2'd1);
      up = 1'b0;
      if (!trunc) begin
         case (r)
            2'd0:    up = (rem > half) || ((rem == half) && ip[0]);
            2'd2:    up = !s && (rem != 0);
            2'd3:    up = s && (rem != 0);
            default: up = 1'b0;
         endcase
      end
      rnd = ip + (up ? 136'(1) : 136'(0));
      val = s ? -rnd : rnd;
      n = t[1] ? 64 : 32;
      if (t[0]) begin lo = 0; hi = (136'(1) << n) - 1; end
      else begin lo = -(136'(1) << (n - 1)); hi = (136'(1) << (n - 1)) - 1; end
      inv = nan || inf || (val > hi) || (val < lo);
      if (nan)          raw = (m[2:1] == 2'd0) ? lo[63:0] : 64'd0;
      else if (m[2])    raw = inf ? 64'd0 : val[63:0];
      else if (inf)     raw = s ? lo[63:0] : hi[63:0];
      else if (val > hi) raw = hi[63:0];
      else if (val < lo) raw = lo[63:0];
      else               raw = val[63:0];
      if (!t[1]) raw = t[0] ? {32'd0, raw[31:0]} : {{32{raw[31]}}, raw[31:0]};
      o.inv  = inv;
      o.ovf  = inv;
      o.snan = snan;
      o.inex = !inv && (rem != 0);
      o.up   = !inv && up;
      o.we   = !(e && inv);
      o.d    = o.we ? raw : 64'd0;
      return o;
   endfunction

   function automatic obs_t sample_out();
      obs_t a;
      a.we = res_we; a.d = res_data; a.inv = flg_invalid; a.snan = flg_snan;
      a.inex = flg_inexact; a.up = flg_rounded_up; a.ovf = flg_overflow; a.ill = flg_illegal;
      return a;
   endfunction

   task automatic compare(input obs_t act, input obs_t ex, input string tag);
      total++;
      if (act !== ex) begin
         bad++;
         $display("FAIL %s: actual we=%0b d=%h inv=%0b snan=%0b inex=%0b up=%0b ovf=%0b ill=%0b expected we=%0b d=%h inv=%0b snan=%0b inex=%0b up=%0b ovf=%0b ill=%0b",
                  tag, act.we, act.d, act.inv, act.snan, act.inex, act.up, act.ovf, act.ill,
                  ex.we, ex.d, ex.inv, ex.snan, ex.inex, ex.up, ex.ovf, ex.ill);
      end
   endtask

   // compares the result of the operands applied one cycle earlier
   always @(negedge clk) begin
      if (mon_on && expq.size() > 0) begin
         obs_t ex;
         string tg;
         ex = expq.pop_front();
         tg = tagq.pop_front();
         compare(sample_out(), ex, tg);
      end
   end

   task automatic drive(input logic v, input logic [31:0] f, input logic [1:0] t,
                        input logic [2:0] m, input logic [1:0] r, input logic e, input string tag);
      @(negedge clk);
      #1;
      op_valid = v; op_src = f; op_tgt = t; op_mode = m; op_rnd = r; inv_en = e;
      expq.push_back(ref_conv(v, f, t, m, r, e));
      tagq.push_back(tag);
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R12 watchdog: actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      rst_n = 1'b0; op_valid = 0; op_src = '0; op_tgt = '0; op_mode = '0; op_rnd = '0; inv_en = 0;
      repeat (3) @(negedge clk);
      compare(sample_out(), obs_t'('0), "R12 reset");
      rst_n = 1'b1;
      mon_on = 1'b1;

      // R12 idle operation
      drive(0, 32'h3F800000, 2, 0, 0, 0, "R12 idle");
      // R1 formats and extension
      drive(1, 32'hBF800000, 0, 0, 0, 0, "R1 s32 -1");
      drive(1, 32'hBF800000, 2, 0, 0, 0, "R1 s64 -1");
      drive(1, 32'h4F000000, 1, 0, 0, 0, "R1 u32 2^31");
      drive(1, 32'hCF000000, 0, 0, 0, 0, "R1 s32 -2^31");
      // R2 rounding directions
      drive(1, 32'h40200000, 2, 0, 0, 0, "R2 near 2.5");
      drive(1, 32'h40200000, 2, 0, 2, 0, "R2 ceil 2.5");
      drive(1, 32'hC0200000, 2, 0, 3, 0, "R2 floor -2.5");
      drive(1, 32'hC0200000, 2, 0, 1, 0, "R2 trunc -2.5");
      drive(1, 32'h3FC00000, 2, 0, 0, 0, "R2 near 1.5");
      drive(1, 32'h40200000, 2, 4, 2, 0, "R2 mode bit2 forces trunc");
      // R3 native policy
      drive(1, 32'h7FC00000, 0, 0, 0, 0, "R3 nan min");
      drive(1, 32'h4F000000, 0, 1, 0, 0, "R3 s32 sat max");
      drive(1, 32'hFF800000, 3, 0, 0, 0, "R3 -inf u64");
      drive(1, 32'h5F800000, 3, 0, 0, 0, "R3 u64 sat max");
      // R4 saturating policy
      drive(1, 32'h7FC00000, 2, 2, 0, 0, "R4 nan zero");
      drive(1, 32'hDF000000, 2, 3, 0, 0, "R4 s64 exact min");
      drive(1, 32'h5F000000, 2, 2, 0, 0, "R4 s64 sat max");
      // R5 modular policy
      drive(1, 32'h53C00000, 0, 4, 0, 0, "R5 wrap 1.5*2^40");
      drive(1, 32'h4F000000, 0, 4, 0, 0, "R5 wrap 2^31 s32");
      drive(1, 32'h7F800000, 2, 5, 0, 0, "R5 inf zero");
      drive(1, 32'h71800000, 3, 4, 0, 0, "R5 wrap 2^100");
      // R6 reserved modes
      drive(1, 32'h3F800000, 2, 6, 0, 0, "R6 mode6");
      drive(1, 32'h7FA00000, 0, 7, 0, 1, "R6 mode7");
      // R7 invalid flags
      drive(1, 32'h4F000000, 0, 0, 0, 0, "R7 overflow write");
      drive(1, 32'hBF400000, 1, 0, 0, 0, "R7 u32 -0.75 rounds to -1");
      // R8 inexact and rounded-up
      drive(1, 32'h3FC00000, 0, 0, 1, 0, "R8 trunc inexact");
      drive(1, 32'hBFC00000, 0, 0, 0, 0, "R8 near up");
      // R9 suppression
      drive(1, 32'h7FC00000, 0, 0, 0, 1, "R9 nan suppressed");
      drive(1, 32'h4F800000, 1, 2, 0, 1, "R9 u32 2^32 suppressed");
      // R10 signalling nan
      drive(1, 32'h7FA00000, 0, 0, 0, 0, "R10 snan");
      drive(1, 32'hFFC00000, 0, 2, 0, 0, "R10 qnan no snan");
      // R11 zero and subnormal
      drive(1, 32'h00000001, 2, 0, 2, 0, "R11 ceil sub");
      drive(1, 32'h80000001, 2, 0, 3, 0, "R11 floor sub");
      drive(1, 32'h00000001, 2, 0, 0, 0, "R11 near sub");
      drive(1, 32'h80000000, 0, 0, 2, 0, "R11 neg zero");

      for (int i = 0; i < 6000; i++) begin
         logic [31:0] f;
         logic [7:0]  ex;
         logic [2:0]  m;
         string tg;
         f  = $urandom;
         case ($urandom_range(0, 7))
            0:       ex = 8'hFF;
            1:       ex = 8'h00;
            2:       ex = 8'(f[30:23]);
            default: ex = 8'($urandom_range(118, 194));
         endcase
         f[30:23] = ex;
         m = 3'($urandom_range(0, 7));
         tg = (m >= 3'd6) ? "R6 random" : (m[2] ? "R5 random" : (m[1] ? "R4 random" : "R3 random"));
         drive(($urandom_range(0, 15) != 0), f, 2'($urandom), m, 2'($urandom),
               1'($urandom), tg);
      end
      drive(0, 32'h0, 0, 0, 0, 0, "R12 drain");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      finish_run();
   end

endmodule